// File: doc/BRIEF.md
# Mixed-mode restart and return sequencer

This block carries out the stack side of software restarts and returns for a processor core that runs in one of two addressing modes. In the 16-bit mode, code and short-stack addresses are formed by placing an 8-bit page base above a 16-bit offset. In the 24-bit mode, addresses are linear and a separate 24-bit long stack is used. A one-bit mode flag selects between the two. Each restart saves the return address, possibly split between the two stacks, and then pushes a marker byte. The marker records which mode the caller was in. A return pops the address back from whichever stack matches the current mode.

The surrounding core hands over a decoded request together with its live state: the mode flag, PC, page base and both stack pointers. The block then drives a byte-wide memory port with one access per cycle. When the sequence completes, it presents the new PC, mode flag and stack pointers, marked by a one-cycle completion pulse. A combination of request and mode that is not defined is refused at once. In that case the block makes no memory access and raises an illegal-instruction pulse.

Top module: `mm_trap_seq`

## Requirements
- R1: After reset, `busy`, `done` and `illegal` are low and no memory access is driven. `pc_o`, `mode_o`, `sps_o` and `spl_o` are all zero.
- R2: Request code 2 (restart into 16-bit mode) is legal only with the mode flag at 1. It writes PC[15:8] and then PC[7:0] to the short stack at {base, short SP}. It then writes PC[23:16] and then the marker 03h to the long stack. Results: mode 0, PC = {base, 00h, vector}, short SP lowered by 2, long SP lowered by 2.
- R3: Request code 3 (restart into 24-bit mode) is legal only with the mode flag at 0. It writes PC[15:8], then PC[7:0], then the marker 02h to the long stack. Results: mode 1, PC = {0000h, vector}, long SP lowered by 3, short SP unchanged.
- R4: Request code 4 (restart staying in 24-bit mode) is legal only with the mode flag at 1. It writes PC[23:16], PC[15:8], PC[7:0] and then the marker 03h to the long stack. Results: mode 1, PC = {0000h, vector}, long SP lowered by 4, short SP unchanged.
- R5: Request code 0 (return) with the mode flag at 0 reads two bytes from {base, short SP}, low byte first. Results: PC = {base, high, low}, short SP raised by 2, mode 0, long SP unchanged.
- R6: Request code 0 with the mode flag at 1 reads three bytes from the long stack, low byte first. Results: PC holds the three bytes, long SP raised by 3, mode 1, short SP unchanged.
- R7: Request code 1 (return with short suffix) with the mode flag at 0 is refused. So is every other combination not listed in R2 to R6, including codes 5 to 7. A refused request makes no memory access and never raises `busy`. One cycle after the request, `illegal` pulses for one cycle and the outputs take the unchanged PC, mode and stack pointers given with the request.
- R8: A push first lowers its pointer by one and writes at the new value. A pop reads at the pointer and then raises it by one. The short SP wraps within 16 bits and keeps the page base, while the long SP wraps within 24 bits.
- R9: Exactly one access is made per cycle, and `busy` is high through the cycles that carry accesses. `done` then pulses for one cycle with `busy` low, and the results are valid from that cycle.
- R10: A request presented while `busy` is high is ignored, and the running sequence finishes with its own accesses and results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Request code (0 return, 1 short-suffix return, 2/3/4 restart variants) |
| req_vec | input | 8 | Restart vector byte |
| mode_i | input | 1 | Current mode flag (1 = 24-bit) |
| pc_i | input | 24 | Current PC |
| base_i | input | 8 | Page base register |
| sps_i | input | 16 | Short stack pointer |
| spl_i | input | 24 | Long stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle refusal pulse |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read byte, valid in the cycle of `mem_re` |
| pc_o | output | 24 | Resulting PC |
| mode_o | output | 1 | Resulting mode flag |
| sps_o | output | 16 | Resulting short stack pointer |
| spl_o | output | 24 | Resulting long stack pointer |

## Verification
A fault in the latched step plan shows on the memory port in the first cycle after acceptance. It appears as a wrong address, a wrong byte or the wrong strobe, and every access is compared in order. A pointer that moves the wrong way or fails to wrap makes the next access address wrong within one cycle, and the stack pointers at `done` are wrong as well. A byte popped into the wrong slot appears only in `pc_o` at the completion pulse, so every return checks the whole PC. A missed refusal shows one cycle after the request, either as a raised `busy` or as a missing `illegal` pulse.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LIN_W     = 24;
  localparam int unsigned PG_W      = 16;
  localparam int unsigned BASE_W    = LIN_W - PG_W;
  localparam int unsigned PC_BYTES  = LIN_W / BYTE_W;
  localparam int unsigned SLOT_W    = $clog2(PC_BYTES);
  localparam int unsigned MAX_STEPS = 4;
  localparam int unsigned STEP_IW   = $clog2(MAX_STEPS + 1);
  localparam int unsigned OP_W      = 3;

  localparam logic [BYTE_W-1:0] MARK_FROM24 = 8'h03;
  localparam logic [BYTE_W-1:0] MARK_FROM16 = 8'h02;

  typedef enum logic [OP_W-1:0] {
    OP_RET       = 3'd0,
    OP_RET_SHORT = 3'd1,
    OP_RST_TO16  = 3'd2,
    OP_RST_UP24  = 3'd3,
    OP_RST_KEEP  = 3'd4
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  typedef struct packed {
    logic              on_long;
    logic              wr;
    logic [BYTE_W-1:0] data;
    logic [SLOT_W-1:0] slot;
  } step_t;

  function automatic step_t mk_step(input logic on_long, input logic wr,
                                    input logic [BYTE_W-1:0] data,
                                    input logic [SLOT_W-1:0] slot);
    step_t s;
    s.on_long = on_long;
    s.wr      = wr;
    s.data    = data;
    s.slot    = slot;
    return s;
  endfunction
endpackage

// File: rtl/mts_decode.sv
module mts_decode
  import mts_pkg::*;
(
  input  logic [OP_W-1:0]              op,
  input  logic                         mode,
  input  logic [LIN_W-1:0]             pc,
  input  logic [BYTE_W-1:0]            vec,
  input  logic [BASE_W-1:0]            base,
  output logic                         legal,
  output logic [STEP_IW-1:0]           nsteps,
  output step_t [MAX_STEPS-1:0]        steps,
  output logic                         mode_new,
  output logic [LIN_W-1:0]             pc_tpl
);
  localparam logic [BYTE_W-1:0] ZB = '0;

  logic [BYTE_W-1:0] pc_hi, pc_md, pc_lo;

  assign pc_hi = pc[3*BYTE_W-1:2*BYTE_W];
  assign pc_md = pc[2*BYTE_W-1:BYTE_W];
  assign pc_lo = pc[BYTE_W-1:0];

  always_comb begin
    legal    = 1'b0;
    nsteps   = '0;
    steps    = '0;
    mode_new = mode;
    pc_tpl   = pc;
    case (op)
      OP_RET: begin
        legal = 1'b1;
        if (!mode) begin
          nsteps   = STEP_IW'(2);
          steps[0] = mk_step(1'b0, 1'b0, ZB, SLOT_W'(0));
          steps[1] = mk_step(1'b0, 1'b0, ZB, SLOT_W'(1));
          pc_tpl   = {base, {PG_W{1'b0}}};
        end else begin
          nsteps   = STEP_IW'(3);
          steps[0] = mk_step(1'b1, 1'b0, ZB, SLOT_W'(0));
          steps[1] = mk_step(1'b1, 1'b0, ZB, SLOT_W'(1));
          steps[2] = mk_step(1'b1, 1'b0, ZB, SLOT_W'(2));
          pc_tpl   = '0;
        end
      end
      OP_RST_TO16: begin
        if (mode) begin
          legal    = 1'b1;
          nsteps   = STEP_IW'(4);
          steps[0] = mk_step(1'b0, 1'b1, pc_md, '0);
          steps[1] = mk_step(1'b0, 1'b1, pc_lo, '0);
          steps[2] = mk_step(1'b1, 1'b1, pc_hi, '0);
          steps[3] = mk_step(1'b1, 1'b1, MARK_FROM24, '0);
          mode_new = 1'b0;
          pc_tpl   = {base, ZB, vec};
        end
      end
      OP_RST_UP24: begin
        if (!mode) begin
          legal    = 1'b1;
          nsteps   = STEP_IW'(3);
          steps[0] = mk_step(1'b1, 1'b1, pc_md, '0);
          steps[1] = mk_step(1'b1, 1'b1, pc_lo, '0);
          steps[2] = mk_step(1'b1, 1'b1, MARK_FROM16, '0);
          mode_new = 1'b1;
          pc_tpl   = {ZB, ZB, vec};
        end
      end
      OP_RST_KEEP: begin
        if (mode) begin
          legal    = 1'b1;
          nsteps   = STEP_IW'(4);
          steps[0] = mk_step(1'b1, 1'b1, pc_hi, '0);
          steps[1] = mk_step(1'b1, 1'b1, pc_md, '0);
          steps[2] = mk_step(1'b1, 1'b1, pc_lo, '0);
          steps[3] = mk_step(1'b1, 1'b1, MARK_FROM24, '0);
          mode_new = 1'b1;
          pc_tpl   = {ZB, ZB, vec};
        end
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mts_stack_ptr.sv
module mts_stack_ptr #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] ptr,
  input  logic         step_en,
  input  logic         push,
  output logic [W-1:0] addr,
  output logic [W-1:0] ptr_nxt
);
  logic [W-1:0] ptr_dec, ptr_inc;

  assign ptr_dec = ptr - W'(1);
  assign ptr_inc = ptr + W'(1);

  always_comb begin
    addr    = push ? ptr_dec : ptr;
    ptr_nxt = ptr;
    if (step_en) ptr_nxt = push ? ptr_dec : ptr_inc;
  end
endmodule

// File: rtl/mts_ctrl.sv
module mts_ctrl
  import mts_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_legal,
  input  logic [STEP_IW-1:0] nsteps_q,
  output logic               take_ok,
  output logic               take_bad,
  output logic               running,
  output logic               last_step,
  output logic [STEP_IW-1:0] idx,
  output logic               done,
  output logic               illegal
);
  state_e             state_q, state_d;
  logic [STEP_IW-1:0] idx_q, idx_d;
  logic               done_q, done_d;
  logic               ill_q, ill_d;
  logic               idle;

  assign idle      = (state_q == ST_IDLE);
  assign take_ok   = idle & req_valid & req_legal;
  assign take_bad  = idle & req_valid & ~req_legal;
  assign running   = (state_q == ST_RUN);
  assign last_step = running && (idx_q == STEP_IW'(nsteps_q - STEP_IW'(1)));
  assign idx       = idx_q;
  assign done      = done_q;
  assign illegal   = ill_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    ill_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_ok) begin
          state_d = ST_RUN;
          idx_d   = '0;
        end
        ill_d = take_bad;
      end
      ST_RUN: begin
        if (last_step) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + STEP_IW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      ill_q   <= ill_d;
    end
  end
endmodule

// File: rtl/mm_trap_seq.sv
module mm_trap_seq
  import mts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [BYTE_W-1:0] req_vec,
  input  logic              mode_i,
  input  logic [LIN_W-1:0]  pc_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [PG_W-1:0]   sps_i,
  input  logic [LIN_W-1:0]  spl_i,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [LIN_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [LIN_W-1:0]  pc_o,
  output logic              mode_o,
  output logic [PG_W-1:0]   sps_o,
  output logic [LIN_W-1:0]  spl_o
);
  // decode of the incoming request
  logic                  dec_legal, dec_mode;
  logic [STEP_IW-1:0]    dec_n;
  step_t [MAX_STEPS-1:0] dec_steps;
  logic [LIN_W-1:0]      dec_pc;

  mts_decode u_dec (
    .op(req_op), .mode(mode_i), .pc(pc_i), .vec(req_vec), .base(base_i),
    .legal(dec_legal), .nsteps(dec_n), .steps(dec_steps),
    .mode_new(dec_mode), .pc_tpl(dec_pc)
  );

  // control
  logic               take_ok, take_bad, running, last_step;
  logic [STEP_IW-1:0] idx;
  logic [STEP_IW-1:0] nsteps_q;

  mts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_legal(dec_legal),
    .nsteps_q(nsteps_q), .take_ok(take_ok), .take_bad(take_bad),
    .running(running), .last_step(last_step), .idx(idx),
    .done(done), .illegal(illegal)
  );

  // latched plan and working state
  step_t [MAX_STEPS-1:0] steps_q;
  logic                  mode_nx_q;
  logic [BASE_W-1:0]     base_q;
  logic [PG_W-1:0]       sps_q, sps_d, sps_nxt, sps_addr;
  logic [LIN_W-1:0]      spl_q, spl_d, spl_nxt, spl_addr;
  logic [LIN_W-1:0]      pc_acc_q, pc_acc_d, pc_merge;
  step_t                 cur;
  logic                  plan_en, sps_en, spl_en, acc_en, res_en;
  logic                  step_short, step_long, step_pop;

  assign cur        = steps_q[idx];
  assign step_short = running & ~cur.on_long;
  assign step_long  = running &  cur.on_long;
  assign step_pop   = running & ~cur.wr;

  mts_stack_ptr #(.W(PG_W)) u_sps (
    .ptr(sps_q), .step_en(step_short), .push(cur.wr),
    .addr(sps_addr), .ptr_nxt(sps_nxt)
  );

  mts_stack_ptr #(.W(LIN_W)) u_spl (
    .ptr(spl_q), .step_en(step_long), .push(cur.wr),
    .addr(spl_addr), .ptr_nxt(spl_nxt)
  );

  // memory port
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    if (running) begin
      mem_addr  = cur.on_long ? spl_addr : {base_q, sps_addr};
      mem_we    = cur.wr;
      mem_re    = ~cur.wr;
      mem_wdata = cur.wr ? cur.data : '0;
    end
  end

  // PC byte merge for pops
  always_comb begin
    pc_merge = pc_acc_q;
    if (step_pop) begin
      for (int b = 0; b < int'(PC_BYTES); b++) begin
        if (cur.slot == SLOT_W'(b)) pc_merge[b*BYTE_W +: BYTE_W] = mem_rdata;
      end
    end
  end

  // next-state values and clock enables
  assign plan_en  = take_ok;
  assign sps_en   = take_ok | step_short;
  assign spl_en   = take_ok | step_long;
  assign acc_en   = take_ok | step_pop;
  assign res_en   = last_step | take_bad;
  assign sps_d    = take_ok ? sps_i  : sps_nxt;
  assign spl_d    = take_ok ? spl_i  : spl_nxt;
  assign pc_acc_d = take_ok ? dec_pc : pc_merge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_q   <= '0;
      nsteps_q  <= '0;
      mode_nx_q <= 1'b0;
      base_q    <= '0;
    end else if (plan_en) begin
      steps_q   <= dec_steps;
      nsteps_q  <= dec_n;
      mode_nx_q <= dec_mode;
      base_q    <= base_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sps_q <= '0;
    end else if (sps_en) begin
      sps_q <= sps_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spl_q <= '0;
    end else if (spl_en) begin
      spl_q <= spl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_acc_q <= '0;
    end else if (acc_en) begin
      pc_acc_q <= pc_acc_d;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o   <= '0;
      mode_o <= 1'b0;
      sps_o  <= '0;
      spl_o  <= '0;
    end else if (res_en) begin
      pc_o   <= take_bad ? pc_i   : pc_merge;
      mode_o <= take_bad ? mode_i : mode_nx_q;
      sps_o  <= take_bad ? sps_i  : sps_nxt;
      spl_o  <= take_bad ? spl_i  : spl_nxt;
    end
  end

  assign busy = running;
endmodule

// File: rtl/mts_checker.sv
module mts_checker
  import mts_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic illegal,
  input logic mem_we,
  input logic mem_re
);
  logic [STEP_IW:0] acc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_cnt <= '0;
    else if (!busy)            acc_cnt <= '0;
    else if (mem_we || mem_re) acc_cnt <= acc_cnt + 1'b1;
  end

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re)); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_we && !mem_re)); // R9
  AST_ACCESS_EVERY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (mem_we || mem_re)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> (!busy && !done && !mem_we && !mem_re)); // R7
  AST_REFUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) illegal |=> !illegal); // R7
  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) acc_cnt <= (STEP_IW+1)'(MAX_STEPS)); // R9
endmodule

bind mm_trap_seq mts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .illegal(illegal),
  .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/tb_mm_trap_seq.sv
module tb_mm_trap_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [7:0]  req_vec = '0;
  logic        mode_i = 1'b0;
  logic [23:0] pc_i = '0;
  logic [7:0]  base_i = '0;
  logic [15:0] sps_i = '0;
  logic [23:0] spl_i = '0;
  logic        busy, done, illegal, mem_we, mem_re, mode_o;
  logic [23:0] mem_addr, pc_o, spl_o;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] sps_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int log_n = 0;
  int log_start = 0;
  int run_cycles = 0;
  bit busy_gap = 0;
  bit          log_we   [0:63];
  logic [23:0] log_addr [0:63];
  logic [7:0]  log_data [0:63];
  logic [7:0]  mem [logic [23:0]];

  always #2 clk = ~clk;

  mm_trap_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_vec(req_vec), .mode_i(mode_i), .pc_i(pc_i), .base_i(base_i),
    .sps_i(sps_i), .spl_i(spl_i), .busy(busy), .done(done), .illegal(illegal),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .pc_o(pc_o), .mode_o(mode_o), .sps_o(sps_o), .spl_o(spl_o)
  );

  // memory model: reads served and all accesses logged away from the clock edge
  always @(negedge clk) begin
    if (mem_re) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    else        mem_rdata <= 8'h00;
    if ((mem_we || mem_re) && log_n < 64) begin
      log_we[log_n]   = mem_we;
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_we ? mem_wdata : 8'h00;
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_acc(input int k, input bit we, input logic [23:0] addr,
                         input logic [7:0] data, input string req);
    int i;
    i = log_start + k;
    chk(log_we[i] == we, req, $sformatf("access %0d direction", k), 32'(log_we[i]), 32'(we));
    chk(log_addr[i] == addr, req, $sformatf("access %0d address", k), 32'(log_addr[i]), 32'(addr));
    if (we) chk(log_data[i] == data, req, $sformatf("access %0d byte", k), 32'(log_data[i]), 32'(data));
  endtask

  task automatic chk_out(input logic [23:0] pc, input logic m, input logic [15:0] sp16,
                         input logic [23:0] sp24, input string req);
    chk(pc_o == pc, req, "pc_o", 32'(pc_o), 32'(pc));
    chk(mode_o == m, req, "mode_o", 32'(mode_o), 32'(m));
    chk(sps_o == sp16, req, "sps_o", 32'(sps_o), 32'(sp16));
    chk(spl_o == sp24, req, "spl_o", 32'(spl_o), 32'(sp24));
  endtask

  // starts at a falling edge, returns at the falling edge where done or illegal is seen
  task automatic run_op(input logic [2:0] op, input logic m, input logic [23:0] pc,
                        input logic [7:0] vec, input logic [7:0] base,
                        input logic [15:0] sp16, input logic [23:0] sp24, input bit poke);
    int cyc;
    req_op = op; mode_i = m; pc_i = pc; req_vec = vec; base_i = base;
    sps_i = sp16; spl_i = sp24; req_valid = 1'b1;
    log_start = log_n;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    busy_gap = 0;
    while (!done && !illegal && cyc < 20) begin
      if (!busy) busy_gap = 1;
      if (poke && cyc == 1) begin
        req_valid = 1'b1; req_op = 3'd0; mode_i = ~m; pc_i = 24'hFFFFFF;
        sps_i = 16'h5555; spl_i = 24'hAAAAAA; base_i = 8'h99;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    run_cycles = cyc;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !illegal, "R1", "busy/done/illegal", {29'd0, busy, done, illegal}, 32'd0);
    chk(!mem_we && !mem_re, "R1", "memory strobes", {30'd0, mem_we, mem_re}, 32'd0);
    chk_out(24'h0, 1'b0, 16'h0, 24'h0, "R1");
  endtask

  task automatic t_rst_to16;
    run_op(3'd2, 1'b1, 24'h123456, 8'h38, 8'hAB, 16'h1000, 24'h200000, 1'b0);
    chk(done && !busy, "R9", "done pulse with busy low", {30'd0, done, busy}, 32'd2);
    chk(run_cycles == 4 && !busy_gap, "R9", "busy cycles", 32'(run_cycles), 32'd4);
    chk(log_n - log_start == 4, "R2", "access count", 32'(log_n - log_start), 32'd4);
    chk_acc(0, 1'b1, 24'hAB0FFF, 8'h34, "R2");
    chk_acc(1, 1'b1, 24'hAB0FFE, 8'h56, "R2");
    chk_acc(2, 1'b1, 24'h1FFFFF, 8'h12, "R2");
    chk_acc(3, 1'b1, 24'h1FFFFE, 8'h03, "R2");
    chk_out(24'hAB0038, 1'b0, 16'h0FFE, 24'h1FFFFE, "R2");
    @(negedge clk);
    chk(!done, "R9", "done lasts one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_rst_up24;
    run_op(3'd3, 1'b0, 24'hAB4321, 8'h10, 8'h5C, 16'h2222, 24'h000100, 1'b0);
    chk(log_n - log_start == 3, "R3", "access count", 32'(log_n - log_start), 32'd3);
    chk_acc(0, 1'b1, 24'h0000FF, 8'h43, "R3");
    chk_acc(1, 1'b1, 24'h0000FE, 8'h21, "R3");
    chk_acc(2, 1'b1, 24'h0000FD, 8'h02, "R3");
    chk_out(24'h000010, 1'b1, 16'h2222, 24'h0000FD, "R3");
  endtask

  task automatic t_rst_keep_wrap;
    // long pointer wraps below zero (R8)
    run_op(3'd4, 1'b1, 24'h89ABCD, 8'h08, 8'h01, 16'h3333, 24'h000002, 1'b0);
    chk(log_n - log_start == 4, "R4", "access count", 32'(log_n - log_start), 32'd4);
    chk_acc(0, 1'b1, 24'h000001, 8'h89, "R4");
    chk_acc(1, 1'b1, 24'h000000, 8'hAB, "R4");
    chk_acc(2, 1'b1, 24'hFFFFFF, 8'hCD, "R8");
    chk_acc(3, 1'b1, 24'hFFFFFE, 8'h03, "R8");
    chk_out(24'h000008, 1'b1, 16'h3333, 24'hFFFFFE, "R4");
  endtask

  task automatic t_ret16_wrap;
    mem[24'h7EFFFF] = 8'h22;
    mem[24'h7E0000] = 8'h11;
    run_op(3'd0, 1'b0, 24'h7E4444, 8'h00, 8'h7E, 16'hFFFF, 24'h456789, 1'b0);
    chk(log_n - log_start == 2, "R5", "access count", 32'(log_n - log_start), 32'd2);
    chk_acc(0, 1'b0, 24'h7EFFFF, 8'h00, "R5");
    chk_acc(1, 1'b0, 24'h7E0000, 8'h00, "R8");
    chk_out(24'h7E1122, 1'b0, 16'h0001, 24'h456789, "R5");
  endtask

  task automatic t_ret24;
    mem[24'h300000] = 8'h33;
    mem[24'h300001] = 8'h22;
    mem[24'h300002] = 8'h11;
    run_op(3'd0, 1'b1, 24'h000777, 8'h00, 8'h12, 16'h4444, 24'h300000, 1'b0);
    chk(log_n - log_start == 3, "R6", "access count", 32'(log_n - log_start), 32'd3);
    chk_acc(0, 1'b0, 24'h300000, 8'h00, "R6");
    chk_acc(2, 1'b0, 24'h300002, 8'h00, "R6");
    chk_out(24'h112233, 1'b1, 16'h4444, 24'h300003, "R6");
  endtask

  task automatic t_refuse(input logic [2:0] op, input logic m);
    run_op(op, m, 24'h6A5B4C, 8'h20, 8'h3D, 16'hBEEF, 24'hC0FFEE, 1'b0);
    chk(illegal && !busy && !done, "R7", $sformatf("refusal pulse op %0d mode %0d", op, m),
        {29'd0, illegal, busy, done}, 32'd4);
    chk(run_cycles == 0 && log_n == log_start, "R7", "no access on refusal",
        32'(log_n - log_start), 32'd0);
    chk_out(24'h6A5B4C, m, 16'hBEEF, 24'hC0FFEE, "R7");
    @(negedge clk);
    chk(!illegal && !busy, "R7", "refusal lasts one cycle", {30'd0, illegal, busy}, 32'd0);
  endtask

  task automatic t_busy_ignore;
    run_op(3'd4, 1'b1, 24'h102030, 8'h18, 8'h00, 16'h0100, 24'h050000, 1'b1);
    chk(run_cycles == 4 && !busy_gap, "R10", "sequence length unchanged", 32'(run_cycles), 32'd4);
    chk(log_n - log_start == 4, "R10", "access count", 32'(log_n - log_start), 32'd4);
    chk_acc(1, 1'b1, 24'h04FFFE, 8'h20, "R10");
    chk_acc(3, 1'b1, 24'h04FFFC, 8'h03, "R10");
    chk_out(24'h000018, 1'b1, 16'h0100, 24'h04FFFC, "R10");
    @(negedge clk);
    chk(!busy && !done, "R10", "no second sequence", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=%0d expected=<100000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rst_to16();
    t_rst_up24();
    t_rst_keep_wrap();
    t_ret16_wrap();
    t_ret24();
    t_refuse(3'd1, 1'b0);
    t_refuse(3'd2, 1'b0);
    t_refuse(3'd3, 1'b1);
    t_refuse(3'd7, 1'b1);
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule